// File: doc/BRIEF.md
# Smart Card Clock and Data Pin Controller

This block sits between a CPU register bus and the two pins that reach an external smart card: the card clock and the bidirectional data line. One 8-bit control register lets software stop the card clock at a chosen idle level, set the data line direction, drive the data line, and read it back. The running card clock is produced by a divider elsewhere and arrives as `clk_src`, a level in the `clk` domain. The operating mode is chosen by other logic and arrives on `mode`.

Bypass mode gives software direct control of both pins. In bypass, the idle-level bit drives the clock pin and the data bits drive or sample the pin. Sync mode keeps the card clock running and latches the data pin on every rising clock edge. In asynchronous mode the data pad belongs to a character engine outside this block, which drives `auto_sio_o` and `auto_sio_oe`, and the data bits of the register do not reach the pad. Clock stop works in every mode except bypass. Both stop and restart wait until the running clock sits at the idle level, so software can carry out a card clock-stop procedure without producing shortened pulses.

The block has no data stream, so it has no valid/ready handshake. Every pin is plain control or status. The bus is a single-cycle write strobe with a combinational read.

Top module: `sc_clkio_ctl`

## Requirements
- R1: After reset the register reads 0x00, the clock pin is low, and the data pad follows `auto_sio_oe`/`auto_sio_o`.
- R2: The register sits at address REG_ADDR. Bit 0 is clock stop, bit 1 is the idle level, bit 2 is direction (1 = input), bit 3 is the data bit, and bits 7:4 read 0. A write to any other address leaves the register unchanged, and a read of any other address returns 0x00.
- R3: Outside bypass mode, with clock stop set, the clock pin is held at the idle level once `clk_src` has reached that level.
- R4: Stop and restart take effect only while `clk_src` equals the idle level, so every high pulse on the clock pin lasts a full `clk_src` high phase.
- R5: In bypass mode the clock pin equals the idle-level bit, one cycle after that bit is written, whatever the clock-stop bit holds.
- R6: In bypass or sync mode, `sio_oe` is 1 exactly when the direction bit is 0, and `sio_o` then equals the data bit.
- R7: In bypass mode with direction = 1, a read of bit 3 returns `sio_i` after SYNC_STAGES clock edges of synchronization.
- R8: In sync mode, bit 3 reads the synchronized `sio_i` value latched on the most recent rising edge of the clock pin. Falling edges do not update it.
- R9: In asynchronous mode (`mode` 0 or 3), `sio_oe`/`sio_o` equal `auto_sio_oe`/`auto_sio_o`, and the register data and direction bits have no effect on them.
- R10: While the clock runs outside bypass, the clock pin equals `clk_src` delayed by one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Operating mode: 0 async, 1 bypass, 2 sync, 3 async |
| clk_src | input | 1 | Running card clock level from the divider |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| sclk_o | output | 1 | Card clock pin |
| sio_i | input | 1 | Data pad input (asynchronous) |
| sio_o | output | 1 | Data pad output value |
| sio_oe | output | 1 | Data pad output enable |
| auto_sio_o | input | 1 | Data output from the async character engine |
| auto_sio_oe | input | 1 | Output enable from the async character engine |

## Verification
The bench builds the block with REG_ADDR = 5 and SYNC_STAGES = 3. These values differ from the defaults, so the bench exercises both the address decode and a synchronizer longer than the minimum. With three stages, the delay before a pin change appears in the register is longer than in the default build, and the bypass and sync read checks are timed against that delay. The card clock source toggles every four cycles. This makes any shortened pulse at stop or restart show up as a high run other than four cycles, and the bench repeats stop and restart at several phases of the source.

// File: rtl/sc_clkio_pkg.sv
package sc_clkio_pkg;

  localparam int CTL_W    = 8;
  localparam int BIT_STOP = 0;
  localparam int BIT_LVL  = 1;
  localparam int BIT_DIR  = 2;
  localparam int BIT_IO   = 3;

  typedef enum logic [1:0] {
    MODE_ASYNC  = 2'd0,
    MODE_BYPASS = 2'd1,
    MODE_SYNC   = 2'd2,
    MODE_RSVD   = 2'd3
  } sc_mode_e;

  typedef struct packed {
    logic io_val;
    logic dir_in;
    logic idle_lvl;
    logic stop;
  } sc_ctl_t;

  function automatic logic pin_owned(sc_mode_e m);
    return (m == MODE_BYPASS) || (m == MODE_SYNC);
  endfunction

endpackage

// File: rtl/sc_clkio_regs.sv
module sc_clkio_regs
  import sc_clkio_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'hB
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [CTL_W-1:0]    bus_wdata,
  input  logic                io_rd,
  output sc_ctl_t             ctl,
  output logic [CTL_W-1:0]    bus_rdata
);

  logic hit;
  logic unused_wdata_hi;

  assign hit             = (bus_addr == REG_ADDR);
  assign unused_wdata_hi = ^bus_wdata[CTL_W-1:BIT_IO+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (bus_wr && hit) begin
      ctl.stop     <= bus_wdata[BIT_STOP];
      ctl.idle_lvl <= bus_wdata[BIT_LVL];
      ctl.dir_in   <= bus_wdata[BIT_DIR];
      ctl.io_val   <= bus_wdata[BIT_IO];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      bus_rdata[BIT_STOP] = ctl.stop;
      bus_rdata[BIT_LVL]  = ctl.idle_lvl;
      bus_rdata[BIT_DIR]  = ctl.dir_in;
      bus_rdata[BIT_IO]   = io_rd;
    end
  end

  AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit) |=> $stable(ctl)); // R2
  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[CTL_W-1:BIT_IO+1] == '0); // R2

endmodule

// File: rtl/sc_clkio_clkgate.sv
module sc_clkio_clkgate
  import sc_clkio_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  sc_mode_e mode,
  input  logic     clk_src,
  input  logic     stop,
  input  logic     idle_lvl,
  output logic     sclk_o,
  output logic     sclk_rise
);

  logic stopped_q;
  logic sclk_q;
  logic sclk_d;
  logic bypass;

  assign bypass = (mode == MODE_BYPASS);

  // The gate state moves only when the source already sits at the idle level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stopped_q <= 1'b0;
    end else if (clk_src == idle_lvl) begin
      stopped_q <= stop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      sclk_d <= sclk_q;
      if (bypass || stopped_q) sclk_q <= idle_lvl;
      else                     sclk_q <= clk_src;
    end
  end

  assign sclk_o    = sclk_q;
  assign sclk_rise = sclk_q & ~sclk_d;

  AST_STOPPED_HOLDS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped_q && !bypass) |=> (sclk_o == $past(idle_lvl))); // R3
  AST_GATE_AT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped_q != $past(stopped_q)) |-> ($past(clk_src) == $past(idle_lvl))); // R4
  AST_BYPASS_DRIVES_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (sclk_o == $past(idle_lvl))); // R5
  AST_SRC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !stopped_q) |=> (sclk_o == $past(clk_src))); // R10

endmodule

// File: rtl/sc_clkio_iopath.sv
module sc_clkio_iopath
  import sc_clkio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  sc_mode_e mode,
  input  logic     dir_in,
  input  logic     io_val,
  input  logic     sclk_rise,
  input  logic     sio_i,
  input  logic     auto_sio_o,
  input  logic     auto_sio_oe,
  output logic     sio_o,
  output logic     sio_oe,
  output logic     io_rd
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic          sio_s;
  logic          cap_q;
  logic          owned;

  generate
    if (SYNC_STAGES < 2) begin : g_bad
      initial $fatal(1, "SYNC_STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[LAST-1:0], sio_i};
  end
  assign sio_s = sync_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             cap_q <= 1'b0;
    else if (mode == MODE_SYNC && sclk_rise) cap_q <= sio_s;
  end

  always_comb begin
    unique case (mode)
      MODE_BYPASS: io_rd = dir_in ? sio_s : io_val;
      MODE_SYNC:   io_rd = cap_q;
      default:     io_rd = io_val;
    endcase
  end

  assign owned  = pin_owned(mode);
  assign sio_oe = owned ? ~dir_in : auto_sio_oe;
  assign sio_o  = owned ? io_val  : auto_sio_o;

  AST_INPUT_NEVER_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && dir_in) |-> !sio_oe); // R6
  AST_SYNC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SYNC && sclk_rise) |=> (mode != MODE_SYNC || io_rd == $past(sio_s))); // R8
  AST_ASYNC_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    !owned |-> (sio_oe == auto_sio_oe && sio_o == auto_sio_o)); // R9

endmodule

// File: rtl/sc_clkio_ctl.sv
module sc_clkio_ctl
  import sc_clkio_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 'hB,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              clk_src,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              sclk_o,
  input  logic              sio_i,
  output logic              sio_o,
  output logic              sio_oe,
  input  logic              auto_sio_o,
  input  logic              auto_sio_oe
);

  sc_mode_e mode_e;
  sc_ctl_t  ctl;
  logic     io_rd;
  logic     sclk_rise;

  assign mode_e = sc_mode_e'(mode);

  sc_clkio_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .io_rd     (io_rd),
    .ctl       (ctl),
    .bus_rdata (bus_rdata)
  );

  sc_clkio_clkgate u_clkgate (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_e),
    .clk_src   (clk_src),
    .stop      (ctl.stop),
    .idle_lvl  (ctl.idle_lvl),
    .sclk_o    (sclk_o),
    .sclk_rise (sclk_rise)
  );

  sc_clkio_iopath #(.SYNC_STAGES(SYNC_STAGES)) u_iopath (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode_e),
    .dir_in      (ctl.dir_in),
    .io_val      (ctl.io_val),
    .sclk_rise   (sclk_rise),
    .sio_i       (sio_i),
    .auto_sio_o  (auto_sio_o),
    .auto_sio_oe (auto_sio_oe),
    .sio_o       (sio_o),
    .sio_oe      (sio_oe),
    .io_rd       (io_rd)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $rose(rst_n) |-> (bus_wr || bus_addr != REG_ADDR || bus_rdata[3:0] == 4'h0)); // R1

endmodule

// File: tb/sc_clkio_ctl_bench.sv
module sc_clkio_ctl_bench;

  localparam int         ADDR_W = 4;
  localparam logic [3:0] RA     = 4'h5;
  localparam int         SYNC   = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       clk_src;
  logic [3:0] bus_addr = 4'h0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sclk_o;
  logic       sio_i = 1'b0;
  logic       sio_o;
  logic       sio_oe;
  logic       auto_sio_o = 1'b0;
  logic       auto_sio_oe = 1'b0;

  always #4 clk = ~clk;

  sc_clkio_ctl #(.ADDR_W(ADDR_W), .REG_ADDR(RA), .SYNC_STAGES(SYNC)) u_sc_clkio_ctl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .clk_src(clk_src),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk_o(sclk_o), .sio_i(sio_i), .sio_o(sio_o), .sio_oe(sio_oe),
    .auto_sio_o(auto_sio_o), .auto_sio_oe(auto_sio_oe)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // clock source: free-running divider model or manual level
  logic src_run = 1'b0;
  logic src_auto = 1'b0;
  logic src_man = 1'b0;
  int   src_cnt = 0;
  assign clk_src = src_run ? src_auto : src_man;

  always @(negedge clk) begin
    if (src_run) begin
      src_cnt++;
      if (src_cnt == 4) begin
        src_cnt = 0;
        src_auto <= ~src_auto;
      end
    end
  end

  // scoreboard for register reads
  typedef struct {
    string      req;
    logic [7:0] exp;
  } rd_item_t;
  rd_item_t sbq[$];
  logic     rd_v = 1'b0;

  always @(posedge clk) begin
    if (rd_v) begin
      rd_item_t it;
      #2;
      if (sbq.size() == 0) begin
        check("scoreboard", 1, 0);
      end else begin
        it = sbq.pop_front();
        check(it.req, bus_rdata, it.exp);
      end
    end
  end

  // pulse width monitor on the card clock pin, R4
  logic wchk = 1'b0;
  int   hi_len = 0;
  int   hi_runs = 0;
  always @(negedge clk) begin
    if (wchk) begin
      if (sclk_o) hi_len++;
      else if (hi_len != 0) begin
        check("R4 high pulse width", hi_len, 4);
        hi_runs++;
        hi_len = 0;
      end
    end else begin
      hi_len = 0;
    end
  end

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] exp, string req);
    rd_item_t it;
    @(negedge clk);
    bus_addr = a;
    it.req = req;
    it.exp = exp;
    sbq.push_back(it);
    rd_v = 1'b1;
    @(negedge clk);
    rd_v = 1'b0;
  endtask

  task automatic hold_check(string req, logic exp, int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sclk_o !== exp) bad++;
    end
    check(req, bad, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(RA, 8'h00, "R1 reset value");
    check("R1 sclk low", sclk_o, 0);
    check("R1 pad follows async oe", sio_oe, 0);

    // R2 layout, foreign address
    wr(RA, 8'hFF);
    rd(RA, 8'h0F, "R2 high bits zero");
    wr(4'h3, 8'h00);
    rd(RA, 8'h0F, "R2 foreign write ignored");
    rd(4'h3, 8'h00, "R2 foreign read zero");
    wr(RA, 8'h00);
    repeat (4) @(negedge clk);

    // R10 one-stage latency
    src_man = 1'b1;
    #1 check("R10 before edge", sclk_o, 0);
    @(negedge clk);
    check("R10 after edge", sclk_o, 1);
    src_man = 1'b0;
    repeat (2) @(negedge clk);

    // R9 async mode pass-through
    wr(RA, 8'h08);
    #1;
    check("R9 oe from engine", sio_oe, 0);
    check("R9 data from engine", sio_o, 0);
    auto_sio_oe = 1'b1;
    auto_sio_o  = 1'b1;
    #1;
    check("R9 oe follows engine", sio_oe, 1);
    check("R9 data follows engine", sio_o, 1);
    auto_sio_oe = 1'b0;
    auto_sio_o  = 1'b0;

    // R6 bypass output control
    @(negedge clk);
    mode = 2'd1;
    #1;
    check("R6 bypass oe", sio_oe, 1);
    check("R6 bypass data 1", sio_o, 1);
    wr(RA, 8'h00);
    check("R6 bypass data 0", sio_o, 0);
    wr(RA, 8'h04);
    check("R6 input no drive", sio_oe, 0);

    // R7 bypass pin read through synchronizer
    sio_i = 1'b1;
    repeat (SYNC + 2) @(negedge clk);
    rd(RA, 8'h0C, "R7 pin high");
    sio_i = 1'b0;
    repeat (SYNC + 2) @(negedge clk);
    rd(RA, 8'h04, "R7 pin low");

    // R5 bypass clock level, stop bit ignored
    src_run = 1'b1;
    wr(RA, 8'h02);
    hold_check("R5 bypass level 1 stop 0", 1'b1, 16);
    wr(RA, 8'h01);
    @(negedge clk);
    hold_check("R5 bypass level 0 stop 1", 1'b0, 16);

    // R3 stop holds idle level
    @(negedge clk);
    mode = 2'd0;
    wr(RA, 8'h01);
    repeat (10) @(negedge clk);
    hold_check("R3 stopped low", 1'b0, 16);
    wr(RA, 8'h03);
    repeat (10) @(negedge clk);
    hold_check("R3 stopped high", 1'b1, 16);

    // R4 no runt pulses across stop and restart at several phases
    wr(RA, 8'h00);
    repeat (10) @(negedge clk);
    while (sclk_o) @(negedge clk);
    wchk = 1'b1;
    for (int k = 0; k < 4; k++) begin
      repeat (k + 1) @(negedge clk);
      wr(RA, 8'h01);
      repeat (17 + k) @(negedge clk);
      wr(RA, 8'h00);
      repeat (19) @(negedge clk);
    end
    while (sclk_o) @(negedge clk);
    @(negedge clk);
    wchk = 1'b0;
    check("R4 pulses observed", (hi_runs >= 8) ? 1 : 0, 1);

    // R8 sync mode capture on rising edge
    src_run = 1'b0;
    src_man = 1'b0;
    mode = 2'd2;
    wr(RA, 8'h04);
    sio_i = 1'b1;
    repeat (6) @(negedge clk);
    src_man = 1'b1;
    repeat (3) @(negedge clk);
    sio_i = 1'b0;
    repeat (6) @(negedge clk);
    rd(RA, 8'h0C, "R8 latched at rise");
    src_man = 1'b0;
    repeat (4) @(negedge clk);
    rd(RA, 8'h0C, "R8 falling edge no update");
    src_man = 1'b1;
    repeat (4) @(negedge clk);
    rd(RA, 8'h04, "R8 next rise");
    wr(RA, 8'h08);
    check("R6 sync oe", sio_oe, 1);
    check("R6 sync data", sio_o, 1);

    repeat (3) @(negedge clk);
    check("scoreboard drained", sbq.size(), 0);
    finish_run();
  end

endmodule